// File: doc/BRIEF.md
# Windowed FIFO Occupancy and Commit Tracker

This block does the counting for a pair of byte FIFOs whose storage the host reaches as plain RAM windows. On the transmit side the host copies a block of bytes into the transmit window. It then writes the block length to the transmit control port, and the tracker adds that many bytes to the fill count and moves the write pointer forward. On the receive side the host copies bytes out of the receive window. It then writes the number it took to the receive control port, and the tracker removes them from the count and moves the read pointer. The serial engine on the far side of each FIFO pops single bytes from transmit and pushes single bytes into receive, one strobe per byte.

Each FIFO spans 1024 byte addresses, so its pointers wrap modulo 1024. Only 1020 bytes may be occupied at once, because the last 32-bit word of the receive window cannot be read. Two 3-bit trigger levels select thresholds of 4 << level bytes. The transmit-space request rises once free space reaches the transmit threshold. The receive-data request rises once the receive count reaches the receive threshold. A host update larger than the space or data available is trimmed to fit, and a sticky error flag records it. The tracker does not contain the RAM arrays or the serializer.

Top module: `hsfifo_ctrl`

## Requirements
- R1: After reset, both fill counts, all four pointers and both error flags are zero.
- R2: A transmit commit of N bytes that fits adds N to the transmit fill count and to the transmit write pointer at the next clock edge. The transmit control readback word carries the fill count in bits [25:16] and the write pointer in bits [9:0], and every other bit is zero.
- R3: A transmit commit larger than 1020 minus the current fill is trimmed to that free space, and the transmit error flag is set and stays set until reset.
- R4: A receive release of N bytes lowers the receive fill count by N and advances the receive read pointer by N. A release larger than the current fill is trimmed to the fill, and the receive error flag is set and stays set until reset.
- R5: An engine push into the receive FIFO adds one byte. A push while the receive fill count is 1020 is ignored, and the count stays at 1020.
- R6: An engine pop from the transmit FIFO removes one byte and advances the transmit read pointer. A pop while the transmit fill count is zero is ignored.
- R7: When a host update and an engine strobe reach the same FIFO in the same cycle, the new fill count is the old count plus the accepted additions minus the accepted removals. Clamping is judged against the old count.
- R8: All pointers wrap from 1023 to 0.
- R9: The transmit-space request is high exactly when 1020 minus the transmit fill count is at least 4 << tx_lvl.
- R10: The receive-data request is high exactly when the receive fill count is at least 4 << rx_lvl.
- R11: Transmitter empty is high exactly when the transmit fill count is zero and the shifter-busy input is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_commit_vld | input | 1 | Host write to transmit control |
| tx_commit_cnt | input | 10 | Byte count committed to transmit |
| rx_release_vld | input | 1 | Host write to receive control |
| rx_release_cnt | input | 10 | Byte count released from receive |
| tx_pop | input | 1 | Serializer takes one transmit byte |
| tx_shift_busy | input | 1 | Serializer still shifting a byte |
| rx_push | input | 1 | Deserializer stores one receive byte |
| tx_lvl | input | 3 | Transmit trigger level |
| rx_lvl | input | 3 | Receive trigger level |
| tx_fill | output | 10 | Transmit fill count |
| tx_wptr | output | 10 | Transmit write pointer |
| tx_rptr | output | 10 | Transmit read pointer |
| rx_fill | output | 10 | Receive fill count |
| rx_wptr | output | 10 | Receive write pointer |
| rx_rptr | output | 10 | Receive read pointer |
| tx_ctrl_rdata | output | 32 | Transmit control readback word |
| tx_space_req | output | 1 | Transmit space request |
| rx_data_req | output | 1 | Receive data request |
| tx_empty | output | 1 | Transmitter empty |
| tx_commit_err | output | 1 | Sticky transmit over-commit flag |
| rx_release_err | output | 1 | Sticky receive over-release flag |

## Verification
The properties assume that the engine strobes are single-cycle and that count inputs matter only while their valid bit is high. Outside those cycles the count inputs may hold any value. The exact-increment properties apply only when no opposing update is present in the same cycle. Mixed cycles are covered by the clamp and cap properties instead. The stimulus drives every input half a period away from the active edge. It holds each valid bit for exactly one cycle and keeps the counts within 10 bits, so each property's precondition is met as written.

// File: rtl/hsf_pkg.sv
package hsf_pkg;
   // Which side of the FIFO the host updates in blocks
   typedef enum logic {
      SIDE_TX = 1'b0,   // host adds by commit, engine pops
      SIDE_RX = 1'b1    // engine pushes, host removes by release
   } fifo_side_e;
endpackage

// File: rtl/hsf_occupancy.sv
module hsf_occupancy #(
   parameter int                  PTR_W  = 10,
   parameter int                  USABLE = 1020,
   parameter hsf_pkg::fifo_side_e SIDE   = hsf_pkg::SIDE_TX
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             host_vld,
   input  logic [PTR_W-1:0] host_cnt,
   input  logic             eng_strb,
   output logic [PTR_W-1:0] fill,
   output logic [PTR_W-1:0] wptr,
   output logic [PTR_W-1:0] rptr,
   output logic             err
);
   localparam int          XW       = PTR_W + 1;
   localparam logic [XW-1:0] USABLE_X = XW'(USABLE);

   if (USABLE >= (1 << PTR_W)) begin : g_bad_usable
      $error("hsf_occupancy: USABLE must be below the pointer range");
   end

   logic [XW-1:0] fill_x, host_x, limit_x, take_x, next_x;
   logic          eng_ok, over;
   logic [PTR_W-1:0] wadv, radv;

   assign fill_x = {1'b0, fill};
   assign host_x = {1'b0, host_cnt};

   if (SIDE == hsf_pkg::SIDE_TX) begin : g_tx
      // host adds bytes, limit is free space; engine removes
      always_comb begin
         limit_x = USABLE_X - fill_x;
         eng_ok  = eng_strb && (fill != '0);
         next_x  = fill_x + take_x - {{PTR_W{1'b0}}, eng_ok};
         wadv    = take_x[PTR_W-1:0];
         radv    = {{(PTR_W-1){1'b0}}, eng_ok};
      end
   end else begin : g_rx
      // engine adds bytes, host removes up to the current fill
      always_comb begin
         limit_x = fill_x;
         eng_ok  = eng_strb && (fill_x < USABLE_X);
         next_x  = fill_x + {{PTR_W{1'b0}}, eng_ok} - take_x;
         wadv    = {{(PTR_W-1){1'b0}}, eng_ok};
         radv    = take_x[PTR_W-1:0];
      end
   end

   always_comb begin
      over   = host_vld && (host_x > limit_x);
      take_x = !host_vld ? '0 : (over ? limit_x : host_x);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fill <= '0;
         wptr <= '0;
         rptr <= '0;
         err  <= 1'b0;
      end else begin
         fill <= next_x[PTR_W-1:0];
         wptr <= wptr + wadv;
         rptr <= rptr + radv;
         if (over) err <= 1'b1;
      end
   end
endmodule

// File: rtl/hsf_trigger.sv
module hsf_trigger #(
   parameter int PTR_W      = 10,
   parameter int USABLE     = 1020,
   parameter int LVL_W      = 3,
   parameter int LVL_SHIFT  = 2
) (
   input  logic [PTR_W-1:0] tx_fill,
   input  logic [PTR_W-1:0] rx_fill,
   input  logic [LVL_W-1:0] tx_lvl,
   input  logic [LVL_W-1:0] rx_lvl,
   output logic             tx_space_req,
   output logic             rx_data_req
);
   localparam int            XW       = PTR_W + 1;
   localparam logic [XW-1:0] USABLE_X = XW'(USABLE);

   if (LVL_SHIFT + (1 << LVL_W) - 1 >= XW) begin : g_bad_lvl
      $error("hsf_trigger: largest threshold exceeds count width");
   end

   logic [XW-1:0] tx_thr, rx_thr, tx_room;

   always_comb begin
      tx_thr       = XW'(1) << (32'(tx_lvl) + LVL_SHIFT);
      rx_thr       = XW'(1) << (32'(rx_lvl) + LVL_SHIFT);
      tx_room      = USABLE_X - {1'b0, tx_fill};
      tx_space_req = (tx_room >= tx_thr);
      rx_data_req  = ({1'b0, rx_fill} >= rx_thr);
   end
endmodule

// File: rtl/hsfifo_ctrl.sv
module hsfifo_ctrl #(
   parameter int PTR_W     = 10,
   parameter int USABLE    = 1020,
   parameter int LVL_W     = 3,
   parameter int LVL_SHIFT = 2,
   parameter int FILL_LSB  = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tx_commit_vld,
   input  logic [PTR_W-1:0] tx_commit_cnt,
   input  logic             rx_release_vld,
   input  logic [PTR_W-1:0] rx_release_cnt,
   input  logic             tx_pop,
   input  logic             tx_shift_busy,
   input  logic             rx_push,
   input  logic [LVL_W-1:0] tx_lvl,
   input  logic [LVL_W-1:0] rx_lvl,
   output logic [PTR_W-1:0] tx_fill,
   output logic [PTR_W-1:0] tx_wptr,
   output logic [PTR_W-1:0] tx_rptr,
   output logic [PTR_W-1:0] rx_fill,
   output logic [PTR_W-1:0] rx_wptr,
   output logic [PTR_W-1:0] rx_rptr,
   output logic [31:0]      tx_ctrl_rdata,
   output logic             tx_space_req,
   output logic             rx_data_req,
   output logic             tx_empty,
   output logic             tx_commit_err,
   output logic             rx_release_err
);
   if (PTR_W > FILL_LSB || FILL_LSB + PTR_W > 32) begin : g_bad_layout
      $error("hsfifo_ctrl: readback fields overlap or overflow 32 bits");
   end

   hsf_occupancy #(.PTR_W(PTR_W), .USABLE(USABLE), .SIDE(hsf_pkg::SIDE_TX)) u_tx (
      .clk      (clk),
      .rst_n    (rst_n),
      .host_vld (tx_commit_vld),
      .host_cnt (tx_commit_cnt),
      .eng_strb (tx_pop),
      .fill     (tx_fill),
      .wptr     (tx_wptr),
      .rptr     (tx_rptr),
      .err      (tx_commit_err)
   );

   hsf_occupancy #(.PTR_W(PTR_W), .USABLE(USABLE), .SIDE(hsf_pkg::SIDE_RX)) u_rx (
      .clk      (clk),
      .rst_n    (rst_n),
      .host_vld (rx_release_vld),
      .host_cnt (rx_release_cnt),
      .eng_strb (rx_push),
      .fill     (rx_fill),
      .wptr     (rx_wptr),
      .rptr     (rx_rptr),
      .err      (rx_release_err)
   );

   hsf_trigger #(.PTR_W(PTR_W), .USABLE(USABLE), .LVL_W(LVL_W), .LVL_SHIFT(LVL_SHIFT)) u_trig (
      .tx_fill      (tx_fill),
      .rx_fill      (rx_fill),
      .tx_lvl       (tx_lvl),
      .rx_lvl       (rx_lvl),
      .tx_space_req (tx_space_req),
      .rx_data_req  (rx_data_req)
   );

   always_comb begin
      tx_ctrl_rdata                      = '0;
      tx_ctrl_rdata[FILL_LSB +: PTR_W]   = tx_fill;
      tx_ctrl_rdata[0 +: PTR_W]          = tx_wptr;
      tx_empty                           = (tx_fill == '0) && !tx_shift_busy;
   end
endmodule

// File: rtl/hsfifo_ctrl_chk.sv
module hsfifo_ctrl_chk #(
   parameter int PTR_W  = 10,
   parameter int USABLE = 1020
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tx_commit_vld,
   input logic [PTR_W-1:0] tx_commit_cnt,
   input logic             tx_pop,
   input logic             tx_shift_busy,
   input logic [PTR_W-1:0] tx_fill,
   input logic [PTR_W-1:0] tx_rptr,
   input logic             tx_commit_err,
   input logic             tx_empty,
   input logic             rx_release_vld,
   input logic [PTR_W-1:0] rx_release_cnt,
   input logic             rx_push,
   input logic [PTR_W-1:0] rx_fill,
   input logic [PTR_W-1:0] rx_wptr,
   input logic             rx_release_err
);
   localparam logic [PTR_W:0] USABLE_X = (PTR_W+1)'(USABLE);

   // R2: a fitting commit with no pop lands exactly
   a_r2_commit_adds: assert property (@(posedge clk) disable iff (!rst_n)
      tx_commit_vld && !tx_pop && ({1'b0, tx_commit_cnt} + {1'b0, tx_fill} <= USABLE_X)
      |=> tx_fill == PTR_W'($past(tx_fill) + $past(tx_commit_cnt)));

   // R3: over-commit raises the flag, which then holds
   a_r3_tx_over: assert property (@(posedge clk) disable iff (!rst_n)
      tx_commit_vld && ({1'b0, tx_commit_cnt} + {1'b0, tx_fill} > USABLE_X) |=> tx_commit_err);
   a_r3_tx_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      tx_commit_err |=> tx_commit_err);

   // R4: over-release raises the flag, which then holds
   a_r4_rx_over: assert property (@(posedge clk) disable iff (!rst_n)
      rx_release_vld && (rx_release_cnt > rx_fill) |=> rx_release_err);
   a_r4_rx_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      rx_release_err |=> rx_release_err);

   // R5: receive count never exceeds the usable size
   a_r5_rx_cap: assert property (@(posedge clk) disable iff (!rst_n)
      {1'b0, rx_fill} <= USABLE_X);

   // R6: a pop on an empty transmit FIFO changes nothing
   a_r6_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
      tx_pop && !tx_commit_vld && (tx_fill == '0) |=> (tx_fill == '0) && $stable(tx_rptr));

   // R8: an accepted push moves the write pointer by one, wrapping
   a_r8_rx_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      rx_push && !rx_release_vld && ({1'b0, rx_fill} < USABLE_X)
      |=> rx_wptr == PTR_W'($past(rx_wptr) + 1'b1));

   // R11: empty never claimed while data or shifter remain
   a_r11_empty: assert property (@(posedge clk) disable iff (!rst_n)
      tx_empty |-> (tx_fill == '0) && !tx_shift_busy);
endmodule

bind hsfifo_ctrl hsfifo_ctrl_chk #(.PTR_W(PTR_W), .USABLE(USABLE)) u_chk (.*);

// File: tb/test_hsfifo_ctrl.sv
module test_hsfifo_ctrl;
   logic       clk = 1'b0;
   logic       rst_n;
   logic       tx_commit_vld, rx_release_vld, tx_pop, tx_shift_busy, rx_push;
   logic [9:0] tx_commit_cnt, rx_release_cnt;
   logic [2:0] tx_lvl, rx_lvl;
   logic [9:0] tx_fill, tx_wptr, tx_rptr, rx_fill, rx_wptr, rx_rptr;
   logic [31:0] tx_ctrl_rdata;
   logic       tx_space_req, rx_data_req, tx_empty, tx_commit_err, rx_release_err;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   always #4 clk = ~clk;   // 125 MHz

   hsfifo_ctrl i_hsfifo_ctrl (.*);

   // commit, pops, pushes, release, exp tx_fill, exp rx_fill, exp tx_wptr
   localparam int VEC [4][7] = '{
      '{100, 10, 20,  5,  90, 15, 100},
      '{500,  0, 30, 45, 590,  0, 600},
      '{  0, 40,  7,  0, 550,  7, 600},
      '{200, 50,  0,  7, 700,  0, 800}
   };

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FIFO check FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic do_commit(input int n);
      @(negedge clk); tx_commit_vld = 1'b1; tx_commit_cnt = 10'(n);
      @(negedge clk); tx_commit_vld = 1'b0;
   endtask

   task automatic do_release(input int n);
      @(negedge clk); rx_release_vld = 1'b1; rx_release_cnt = 10'(n);
      @(negedge clk); rx_release_vld = 1'b0;
   endtask

   task automatic do_pops(input int n);
      for (int i = 0; i < n; i++) begin @(negedge clk); tx_pop = 1'b1; end
      @(negedge clk); tx_pop = 1'b0;
   endtask

   task automatic do_pushes(input int n);
      for (int i = 0; i < n; i++) begin @(negedge clk); rx_push = 1'b1; end
      @(negedge clk); rx_push = 1'b0;
   endtask

   task automatic finish_run;
      if (!done) begin
         done = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FIFO check FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      rst_n = 1'b0; tx_commit_vld = 1'b0; rx_release_vld = 1'b0; tx_pop = 1'b0;
      tx_shift_busy = 1'b0; rx_push = 1'b0; tx_commit_cnt = '0; rx_release_cnt = '0;
      tx_lvl = 3'd5; rx_lvl = 3'd6;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 tx_fill", int'(tx_fill), 0);
      chk("R1 rx_fill", int'(rx_fill), 0);
      chk("R1 pointers", int'(tx_wptr | tx_rptr | rx_wptr | rx_rptr), 0);
      chk("R1 errors", int'({tx_commit_err, rx_release_err}), 0);
      rst_n = 1'b1;

      // R2 R4 R5 R6: vector table
      for (int v = 0; v < 4; v++) begin
         do_commit(VEC[v][0]);
         do_pops(VEC[v][1]);
         do_pushes(VEC[v][2]);
         do_release(VEC[v][3]);
         chk("R2/R6 tx_fill", int'(tx_fill), VEC[v][4]);
         chk("R4/R5 rx_fill", int'(rx_fill), VEC[v][5]);
         chk("R2 tx_wptr field", int'(tx_ctrl_rdata[9:0]), VEC[v][6]);
      end
      chk("R6 tx_rptr", int'(tx_rptr), 100);
      chk("R4 rx_rptr", int'(rx_rptr), 57);

      // R3 R8: over-commit trimmed to 320, write pointer wraps to 96
      chk("R3 no error yet", int'(tx_commit_err), 0);
      do_commit(1023);
      chk("R3 tx_fill clamped", int'(tx_fill), 1020);
      chk("R3 tx error sticky", int'(tx_commit_err), 1);
      chk("R2/R8 readback word", int'(tx_ctrl_rdata), (1020 << 16) | 96);

      // R9: free space against 4 << level
      tx_lvl = 3'd0; #1;
      chk("R9 no space at full", int'(tx_space_req), 0);
      do_pops(4);
      chk("R9 space reaches 4", int'(tx_space_req), 1);
      tx_lvl = 3'd1; #1;
      chk("R9 space below 8", int'(tx_space_req), 0);

      // R7: commit 2 and pop 1 in one cycle, room 4
      @(negedge clk); tx_commit_vld = 1'b1; tx_commit_cnt = 10'd2; tx_pop = 1'b1;
      @(negedge clk); tx_commit_vld = 1'b0; tx_pop = 1'b0;
      chk("R7 same-cycle tx_fill", int'(tx_fill), 1017);
      chk("R3 still set", int'(tx_commit_err), 1);

      // R4: over-release on empty receive FIFO
      chk("R4 no error yet", int'(rx_release_err), 0);
      do_release(3);
      chk("R4 rx_fill stays 0", int'(rx_fill), 0);
      chk("R4 rx error sticky", int'(rx_release_err), 1);

      // R10: threshold 256 at level 6
      do_pushes(255);
      chk("R10 below 256", int'(rx_data_req), 0);
      do_pushes(1);
      chk("R10 at 256", int'(rx_data_req), 1);

      // R5 R8: fill to the cap, extra push ignored, pointer wrapped
      do_pushes(764);
      chk("R5 rx_fill at cap", int'(rx_fill), 1020);
      do_pushes(1);
      chk("R5 push at cap ignored", int'(rx_fill), 1020);
      chk("R8 rx_wptr wrapped", int'(rx_wptr), 53);

      // R6 R11: drain transmit, extra pop ignored, empty needs idle shifter
      do_pops(1018);
      chk("R6 pop at empty ignored", int'(tx_fill), 0);
      tx_shift_busy = 1'b1; #1;
      chk("R11 busy shifter", int'(tx_empty), 0);
      tx_shift_busy = 1'b0; #1;
      chk("R11 idle and empty", int'(tx_empty), 1);

      // R1: reset in mid-operation clears everything
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk);
      chk("R1 rx_fill after reset", int'(rx_fill), 0);
      chk("R1 errors after reset", int'({tx_commit_err, rx_release_err}), 0);
      chk("R1 rx_wptr after reset", int'(rx_wptr), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      finish_run();
   end
endmodule